// File: doc/BRIEF.md
# Signed Pulse-Rate Synapse Multiplier

This block scales the density of a pulse stream by a stored signed weight. Each single-cycle strobe on the input advances a 6-bit state counter. Each magnitude bit of the weight claims its own disjoint set of counter states, and an output pulse is emitted only when the new state belongs to a set whose bit is set. The gain is therefore the magnitude divided by 64, which is always below one. No multiplier is used.

The sign bit of the weight steers every emitted pulse to either an excitatory or an inhibitory output strobe. A surrounding fabric merges many such synapses per neuron. A simple write port loads the weight at any time. The counter phase is kept across writes, so changing the weight does not restart the pattern.

Top module: `prm_synapse`

## Requirements
- R1: The weight is 7 bits in sign-magnitude form: `wr_weight[6]` is the sign and `wr_weight[5:0]` the magnitude. It is stored at the clock edge where `wr_en` is 1, and it governs input pulses presented in later cycles.
- R2: The state counter advances by exactly one, modulo 64, on each cycle with `pulse_in` high. It holds its value on every other cycle.
- R3: Counting k from the magnitude MSB (k=0 is bit 5), bit k selects the states whose lowest k bits are 0 and whose bit k is 1. The state tested is the counter value after the advance. A pulse is emitted when the selecting bit is set. For example, magnitude 32 fires at odd states, and magnitude 1 fires only at state 32. State 0 never fires.
- R4: Over any 64 consecutive input pulses, the number of output pulses equals the magnitude exactly.
- R5: With sign 0 the pulses appear only on `exc_pulse`. With sign 1 they appear only on `inh_pulse`. The two outputs are never high together.
- R6: A magnitude of zero produces no pulse on either output, whatever the input.
- R7: The outputs are registered. A pulse caused by a strobe appears in the following cycle and lasts one cycle. No output pulse appears in a cycle that follows a cycle without a strobe.
- R8: A weight write leaves the counter unchanged. Synchronous reset clears the counter, the weight and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Single-cycle input pulse strobe |
| wr_en | input | 1 | Weight load enable |
| wr_weight | input | 7 | Sign (bit 6) and magnitude (bits 5:0) to load |
| exc_pulse | output | 1 | Excitatory output pulse strobe |
| inh_pulse | output | 1 | Inhibitory output pulse strobe |

## Verification
The hardest condition to reach from the ports is a weight change in the middle of a counter cycle, because the counter itself cannot be observed. The stimulus loads a weight that fires at states 2, 6, 10 and 14. It then sends sixteen strobes and loads magnitude 1, which fires only at state 32. A preserved counter makes the very next sixteenth strobe produce a pulse, while a counter cleared by the write would delay that pulse until the thirty-second strobe. The exact phase of the decode is also checked strobe by strobe from reset against a trailing-zero model.

// File: rtl/prm_pkg.sv
package prm_pkg;
  typedef enum logic {
    ROUTE_EXC = 1'b0,
    ROUTE_INH = 1'b1
  } route_e;
endpackage

// File: rtl/prm_weight_reg.sv
module prm_weight_reg #(
  parameter int MAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [MAG_W:0]   wr_weight,
  output logic [MAG_W-1:0] mag_q,
  output prm_pkg::route_e  sign_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      sign_q <= prm_pkg::ROUTE_EXC;
    end else if (wr_en) begin
      mag_q  <= wr_weight[MAG_W-1:0];
      sign_q <= prm_pkg::route_e'(wr_weight[MAG_W]);
    end
  end
endmodule

// File: rtl/prm_state_ctr.sv
module prm_state_ctr #(
  parameter int MAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [MAG_W-1:0] cnt_q,
  output logic [MAG_W-1:0] cnt_nxt
);
  localparam logic [MAG_W-1:0] ONE = {{(MAG_W-1){1'b0}}, 1'b1};

  assign cnt_nxt = cnt_q + ONE;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/prm_state_sel.sv
module prm_state_sel #(
  parameter int MAG_W = 6
) (
  input  logic [MAG_W-1:0] state,
  input  logic [MAG_W-1:0] mag,
  output logic             fire
);
  logic [MAG_W-1:0] slot;

  for (genvar k = 0; k < MAG_W; k++) begin : g_slot
    if (k == 0) begin : g_top
      assign slot[k] = state[0] & mag[MAG_W-1];
    end else begin : g_low
      assign slot[k] = state[k] & (state[k-1:0] == '0) & mag[MAG_W-1-k];
    end
  end

  assign fire = |slot;
endmodule

// File: rtl/prm_synapse.sv
module prm_synapse #(
  parameter int MAG_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pulse_in,
  input  logic           wr_en,
  input  logic [MAG_W:0] wr_weight,
  output logic           exc_pulse,
  output logic           inh_pulse
);
  logic [MAG_W-1:0] mag_q;
  prm_pkg::route_e  sign_q;
  logic [MAG_W-1:0] cnt_q;
  logic [MAG_W-1:0] cnt_nxt;
  logic             fire;

  prm_weight_reg #(.MAG_W(MAG_W)) u_wreg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_weight(wr_weight),
    .mag_q(mag_q), .sign_q(sign_q)
  );

  prm_state_ctr #(.MAG_W(MAG_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(pulse_in),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  prm_state_sel #(.MAG_W(MAG_W)) u_sel (
    .state(cnt_nxt), .mag(mag_q), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_pulse <= 1'b0;
      inh_pulse <= 1'b0;
    end else begin
      exc_pulse <= pulse_in & fire & (sign_q == prm_pkg::ROUTE_EXC);
      inh_pulse <= pulse_in & fire & (sign_q == prm_pkg::ROUTE_INH);
    end
  end
endmodule

// File: rtl/prm_synapse_chk.sv
module prm_synapse_chk #(
  parameter int MAG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             pulse_in,
  input logic             wr_en,
  input logic             exc_pulse,
  input logic             inh_pulse,
  input logic [MAG_W-1:0] cnt_q,
  input logic [MAG_W-1:0] mag_q,
  input logic             sign_q
);
  p_one_line_r5: assert property (@(posedge clk) disable iff (rst)
    !(exc_pulse && inh_pulse));

  p_route_exc_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && sign_q) |=> !exc_pulse);

  p_route_inh_r5: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && !sign_q) |=> !inh_pulse);

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    pulse_in |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !pulse_in |=> $stable(cnt_q));

  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !pulse_in |=> !(exc_pulse || inh_pulse));

  p_zero_mag_r6: assert property (@(posedge clk) disable iff (rst)
    (mag_q == '0) |=> !(exc_pulse || inh_pulse));

  p_write_keeps_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !pulse_in) |=> $stable(cnt_q));
endmodule

bind prm_synapse prm_synapse_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .pulse_in(pulse_in), .wr_en(wr_en),
  .exc_pulse(exc_pulse), .inh_pulse(inh_pulse),
  .cnt_q(cnt_q), .mag_q(mag_q), .sign_q(sign_q)
);

// File: tb/prm_synapse_tb.sv
module prm_synapse_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_weight = '0;
  logic       exc_pulse;
  logic       inh_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prm_synapse #(.MAG_W(6)) u_dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .wr_en(wr_en),
    .wr_weight(wr_weight), .exc_pulse(exc_pulse), .inh_pulse(inh_pulse)
  );

  localparam int NV = 6;
  localparam logic [6:0] V_W   [NV] = '{7'h3F, 7'h01, 7'h20, 7'h55, 7'h2A, 7'h40};
  localparam int         V_EXC [NV] = '{63, 1, 32, 0, 42, 0};
  localparam int         V_INH [NV] = '{0, 0, 0, 21, 0, 0};

  function automatic bit model_fire(int s, logic [5:0] mag);
    int tz;
    if ((s % 64) == 0) return 1'b0;
    tz = 0;
    while (((s >> tz) & 1) == 0) tz++;
    return mag[5 - tz];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit p, output bit e, output bit i);
    @(negedge clk);
    pulse_in = p;
    @(negedge clk);
    pulse_in = 1'b0;
    e = exc_pulse;
    i = inh_pulse;
  endtask

  task automatic load(logic [6:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_weight = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit e, i;
    int ne, ni, hit;

    // R8: reset state, strobes held during reset
    pulse_in = 1'b1;
    repeat (4) @(negedge clk);
    check(!exc_pulse && !inh_pulse, "R8 reset outputs", int'(exc_pulse | inh_pulse), 0);
    pulse_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R8/R6: weight cleared by reset, zero magnitude silent
    ne = 0; ni = 0;
    for (int n = 0; n < 64; n++) begin
      step(1'b1, e, i);
      ne += int'(e); ni += int'(i);
    end
    check(ne == 0 && ni == 0, "R8 R6 cleared weight silent", ne + ni, 0);

    // R3 R7: exact phase from reset, one-cycle registered pulse
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    load(7'h2D);
    for (int s = 1; s <= 64; s++) begin
      step(1'b1, e, i);
      check(e == model_fire(s, 6'h2D) && !i, "R3 phase", int'(e), int'(model_fire(s, 6'h2D)));
      step(1'b0, e, i);
      check(!e && !i, "R7 single-cycle pulse", int'(e | i), 0);
    end

    // R1 R4 R5 R6: vector table, gapped strobe pattern
    for (int v = 0; v < NV; v++) begin
      int sent;
      int gap;
      load(V_W[v]);
      ne = 0; ni = 0; sent = 0; gap = 0;
      while (sent < 64) begin
        bit p;
        p = ((gap % 3) != 1);
        gap++;
        step(p, e, i);
        if (p) sent++;
        ne += int'(e); ni += int'(i);
        if (e && i) check(1'b0, "R5 both lines", 1, 0);
      end
      check(ne == V_EXC[v], "R4 R5 exc count", ne, V_EXC[v]);
      check(ni == V_INH[v], "R4 R5 R1 inh count", ni, V_INH[v]);
    end

    // R7: no strobe, no output even at full magnitude
    load(7'h3F);
    ne = 0;
    for (int n = 0; n < 20; n++) begin
      step(1'b0, e, i);
      ne += int'(e | i);
    end
    check(ne == 0, "R7 idle quiet", ne, 0);

    // R8 R1: counter phase kept across a weight write
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    load(7'h10);
    ne = 0;
    for (int n = 0; n < 16; n++) begin
      step(1'b1, e, i);
      ne += int'(e);
    end
    check(ne == 4, "R3 states 2,6,10,14", ne, 4);
    load(7'h01);
    hit = -1;
    for (int n = 1; n <= 32; n++) begin
      step(1'b1, e, i);
      if (e && hit < 0) hit = n;
    end
    check(hit == 16, "R8 counter kept over write", hit, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule